// File: doc/BRIEF.md
# Multiplexed Pixel Input Deformatter

The deformatter sits behind the pixel input pins of a display output chip. A graphics controller sends pixels over a 12-bit bus at twice the pixel rate, so each pixel arrives as two words: word a, then word b. The block captures each word on one selected edge of an external word clock, pairs the words, and unpacks the pair into a parallel 24-bit pixel according to one of five packing formats. Two formats use all 12 lines to carry 24-bit RGB. Two use 8 lines to carry 16-bit and 15-bit RGB, which are widened to 8 bits per component. One carries 8-bit luma and chroma words in a repeating Cb, Y, Cr, Y order and regroups them into co-sited {Y, Cr, Cb} samples.

The external word clock is oversampled by the block clock, which must run at least twice as fast as the word clock. Capturing on both edges of a pixel-rate clock is therefore handled as a word-rate stream captured on one edge, with a polarity input that chooses the edge. The leading (rising) edge of the active-high horizontal sync realigns pairing, so the next captured word is always word a. The same edge restarts the chroma sequence and loads a new format selection. A data-enable input marks active video. Pixels outside it are replaced by the blanking value of the current format.

Top module: `pix_deformat`

## Requirements
- R1: A word is captured from `word_in` in the block-clock cycle where `wclk` is seen to rise (`edge_sel`=0) or to fall (`edge_sel`=1). Edges of the other polarity capture nothing.
- R2: Captured words alternate as word a and word b. The first word captured after a rising edge of `hsync`, or in the same cycle as that edge, is always word a, whatever words came before.
- R3: `pix_valid` is high for exactly one clock cycle, namely the cycle after each word b is captured. `pix_out` changes only together with that pulse.
- R4: `fmt_sel` is loaded only on an `hsync` rising edge. Codes 5 to 7 load as code 0. `fmt_tag` shows the loaded code, and a change of `fmt_sel` has no effect until the next rising edge.
- R5: Code 0: word a = {G[3:0], B[7:0]}, word b = {R[7:0], G[7:4]}, and `pix_out` = {R, G, B} with R in bits 23:16 and B in bits 7:0.
- R6: Code 1: word a = {G[2:0], B[7:0], G[4]}, word b = {R[7:0], G[7:5], G[3]}, and `pix_out` = {R, G, B}.
- R7: Code 2 (16-bit): word a[7:0] = {G[2:0], B[4:0]}, word b[7:0] = {R[4:0], G[5:3]}. Bits 11:8 are ignored. Each component is widened to 8 bits by repeating its top bits below it.
- R8: Code 3 (15-bit): word a[7:0] = {G[2:0], B[4:0]}, word b[7:0] = {x, R[4:0], G[4:3]}. Bit 7 of word b and bits 11:8 of both words are ignored. Components are widened as in R7.
- R9: Code 4: words carry bytes in bits 7:0, in the order Cb, Y, Cr, Y from each sync edge. The output is {Y, Cr, Cb} with one pixel of lag. The pair (Cb0,Y0) emits the previous held sample, the pair (Cr0,Y1) emits {Y0,Cr0,Cb0}, and the next (Cb1,Y2) emits {Y1,Cr0,Cb0}.
- R10: When `de` is low as word b is captured, an RGB pixel is output as 0. In code 4 the enable travels with the luma, so that luma is later emitted as Y=16, Cr=Cb=128. The first pixel emitted after a sync edge in code 4 is also this blank value.
- R11: After reset, `pix_valid` is 0, `pix_out` is 0 and `fmt_tag` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, at least twice the word clock rate |
| rst | input | 1 | Synchronous active-high reset |
| wclk | input | 1 | External word clock, sampled by `clk` |
| edge_sel | input | 1 | 0: capture on rising `wclk`, 1: capture on falling `wclk` |
| hsync | input | 1 | Horizontal sync, active high; rising edge realigns |
| de | input | 1 | Active-video enable, sampled with word b |
| fmt_sel | input | 3 | Requested packing format code |
| word_in | input | 12 | Multiplexed pixel word bus |
| pix_out | output | 24 | Assembled pixel, {R,G,B} or {Y,Cr,Cb} |
| pix_valid | output | 1 | One-cycle strobe for a new pixel |
| fmt_tag | output | 3 | Format code in force |

## Verification
A pairing phase that is one word off shows on the first pixel after the fault. The halves of the packing come out swapped, and the bench's exact comparison catches that pixel. A lost or extra sync restart, for example, is caught on the first checked pixel after the sync. A stale format register shows as a wrong `fmt_tag` in the cycle after the sync edge, and as a wrongly unpacked pixel on the next pair. A chroma phase that is out of step shows within two pixels, as Cb and Cr swapped or paired with the wrong luma.

// File: rtl/pd_pkg.sv
package pd_pkg;

  typedef enum logic [2:0] {
    FMT_RGB12_A = 3'd0,
    FMT_RGB12_B = 3'd1,
    FMT_RGB16   = 3'd2,
    FMT_RGB15   = 3'd3,
    FMT_YCC     = 3'd4
  } fmt_e;

  localparam logic [7:0] LUMA_BLANK   = 8'd16;
  localparam logic [7:0] CHROMA_BLANK = 8'd128;

  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic fmt_e legal_fmt(input logic [2:0] code);
    fmt_e f;
    if (code > 3'd4) f = FMT_RGB12_A;
    else             f = fmt_e'(code);
    return f;
  endfunction

endpackage

// File: rtl/pd_capture.sv
module pd_capture #(
  parameter int IN_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wclk,
  input  logic            edge_sel,
  input  logic            hsync,
  output logic            word_stb,
  output logic            first_word,
  output logic            sync_rise
);

  logic wclk_q;
  logic hs_q;
  logic realign_pend;

  always_ff @(posedge clk) begin
    wclk_q <= wclk;
    hs_q   <= hsync;
  end

  assign sync_rise = hsync & ~hs_q;
  assign word_stb  = edge_sel ? (wclk_q & ~wclk) : (~wclk_q & wclk);
  assign first_word = word_stb & (realign_pend | sync_rise);

  always_ff @(posedge clk) begin
    if (rst)             realign_pend <= 1'b0;
    else if (word_stb)   realign_pend <= 1'b0;
    else if (sync_rise)  realign_pend <= 1'b1;
  end

endmodule

// File: rtl/pd_pair.sv
module pd_pair #(
  parameter int IN_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            word_stb,
  input  logic            first_word,
  input  logic [IN_W-1:0] word_in,
  output logic [IN_W-1:0] word_a,
  output logic            pair_stb
);

  logic half_seen;

  assign pair_stb = word_stb & half_seen & ~first_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_seen <= 1'b0;
      word_a    <= '0;
    end else if (word_stb) begin
      if (first_word || !half_seen) begin
        word_a    <= word_in;
        half_seen <= 1'b1;
      end else begin
        half_seen <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/pd_rgb_unpack.sv
module pd_rgb_unpack
  import pd_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int C_W  = 8
) (
  input  fmt_e              fmt,
  input  logic [IN_W-1:0]   wa,
  input  logic [IN_W-1:0]   wb,
  output logic [3*C_W-1:0]  rgb
);

  logic [C_W-1:0] r, g, b;

  always_comb begin
    case (fmt)
      FMT_RGB12_B: begin
        b = wa[8:1];
        g = {wb[3:1], wa[0], wb[0], wa[11:9]};
        r = wb[11:4];
      end
      FMT_RGB16: begin
        b = widen5(wa[4:0]);
        g = widen6({wb[2:0], wa[7:5]});
        r = widen5(wb[7:3]);
      end
      FMT_RGB15: begin
        b = widen5(wa[4:0]);
        g = widen5({wb[1:0], wa[7:5]});
        r = widen5(wb[6:2]);
      end
      default: begin
        b = wa[7:0];
        g = {wb[3:0], wa[11:8]};
        r = wb[11:4];
      end
    endcase
    rgb = {r, g, b};
  end

endmodule

// File: rtl/pd_ycc_regroup.sv
module pd_ycc_regroup
  import pd_pkg::*;
#(
  parameter int C_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             pair_stb,
  input  logic             de,
  input  logic [C_W-1:0]   byte_a,
  input  logic [C_W-1:0]   byte_b,
  output logic [3*C_W-1:0] ycc
);

  localparam logic [3*C_W-1:0] BLANK = {LUMA_BLANK, CHROMA_BLANK, CHROMA_BLANK};

  logic           on_cr;
  logic [C_W-1:0] cb_cur, y_first;
  logic           de_first;
  logic [C_W-1:0] y_held, cb_held, cr_held;
  logic           de_held;

  always_comb begin
    if (!on_cr) ycc = de_held  ? {y_held, cr_held, cb_held} : BLANK;
    else        ycc = de_first ? {y_first, byte_a, cb_cur}  : BLANK;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      on_cr    <= 1'b0;
      cb_cur   <= CHROMA_BLANK;
      y_first  <= LUMA_BLANK;
      de_first <= 1'b0;
      y_held   <= LUMA_BLANK;
      cb_held  <= CHROMA_BLANK;
      cr_held  <= CHROMA_BLANK;
      de_held  <= 1'b0;
    end else if (pair_stb) begin
      on_cr <= ~on_cr;
      if (!on_cr) begin
        cb_cur   <= byte_a;
        y_first  <= byte_b;
        de_first <= de;
      end else begin
        cb_held <= cb_cur;
        cr_held <= byte_a;
        y_held  <= byte_b;
        de_held <= de;
      end
    end
  end

endmodule

// File: rtl/pix_deformat.sv
module pix_deformat
  import pd_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int C_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wclk,
  input  logic             edge_sel,
  input  logic             hsync,
  input  logic             de,
  input  logic [2:0]       fmt_sel,
  input  logic [IN_W-1:0]  word_in,
  output logic [3*C_W-1:0] pix_out,
  output logic             pix_valid,
  output logic [2:0]       fmt_tag
);

  localparam int PIX_W = 3 * C_W;

  logic             word_stb, first_word, sync_rise, pair_stb;
  logic [IN_W-1:0]  word_a;
  logic [PIX_W-1:0] rgb_pix, ycc_pix;
  fmt_e             fmt_act;

  pd_capture #(.IN_W(IN_W)) u_cap (
    .clk(clk), .rst(rst), .wclk(wclk), .edge_sel(edge_sel), .hsync(hsync),
    .word_stb(word_stb), .first_word(first_word), .sync_rise(sync_rise)
  );

  pd_pair #(.IN_W(IN_W)) u_pair (
    .clk(clk), .rst(rst), .word_stb(word_stb), .first_word(first_word),
    .word_in(word_in), .word_a(word_a), .pair_stb(pair_stb)
  );

  pd_rgb_unpack #(.IN_W(IN_W), .C_W(C_W)) u_rgb (
    .fmt(fmt_act), .wa(word_a), .wb(word_in), .rgb(rgb_pix)
  );

  pd_ycc_regroup #(.C_W(C_W)) u_ycc (
    .clk(clk), .rst(rst), .restart(sync_rise),
    .pair_stb(pair_stb && fmt_act == FMT_YCC), .de(de),
    .byte_a(word_a[C_W-1:0]), .byte_b(word_in[C_W-1:0]), .ycc(ycc_pix)
  );

  always_ff @(posedge clk) begin
    if (rst)            fmt_act <= FMT_RGB12_A;
    else if (sync_rise) fmt_act <= legal_fmt(fmt_sel);
  end

  assign fmt_tag = fmt_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_out   <= '0;
    end else begin
      pix_valid <= pair_stb;
      if (pair_stb) begin
        if (fmt_act == FMT_YCC) pix_out <= ycc_pix;
        else if (de)            pix_out <= rgb_pix;
        else                    pix_out <= '0;
      end
    end
  end

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic             de,
  input logic             sync_rise,
  input logic             word_stb,
  input logic             pix_valid,
  input logic [PIX_W-1:0] pix_out,
  input logic [2:0]       fmt_tag
);

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);

  // R3
  valid_src_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> $past(word_stb));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> $stable(pix_out));

  // R4
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(sync_rise) |-> $stable(fmt_tag));

  // R4
  tag_range_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_tag <= 3'd4);

  // R10
  rgb_blank_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && fmt_tag != 3'd4 && !$past(de)) |-> pix_out == '0);

endmodule

bind pix_deformat pd_checker #(.PIX_W(3*C_W)) u_pd_chk (
  .clk(clk), .rst(rst), .de(de), .sync_rise(sync_rise), .word_stb(word_stb),
  .pix_valid(pix_valid), .pix_out(pix_out), .fmt_tag(fmt_tag)
);

// File: tb/test_pix_deformat.sv
module test_pix_deformat;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wclk = 1'b0;
  logic        edge_sel = 1'b0;
  logic        hsync = 1'b0;
  logic        de = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [11:0] word_in = '0;
  logic [23:0] pix_out;
  logic        pix_valid;
  logic [2:0]  fmt_tag;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 1'b0;
  logic act_lvl = 1'b1;

  always #10 clk = ~clk;

  pix_deformat i_pix_deformat (
    .clk(clk), .rst(rst), .wclk(wclk), .edge_sel(edge_sel), .hsync(hsync),
    .de(de), .fmt_sel(fmt_sel), .word_in(word_in),
    .pix_out(pix_out), .pix_valid(pix_valid), .fmt_tag(fmt_tag)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put_word(input logic [11:0] w, input logic d);
    @(negedge clk);
    word_in = w; de = d; wclk = act_lvl;
    @(negedge clk);
    wclk = ~act_lvl;
  endtask

  task automatic pair_chk(input logic [11:0] a, input logic [11:0] b, input logic d,
                          input logic [23:0] exp, input string req);
    put_word(a, d);
    check(pix_valid == 1'b0, {req, " no pixel after word a"}, {31'd0, pix_valid}, 32'd0);
    put_word(b, d);
    check(pix_valid == 1'b1, {req, " valid after word b"}, {31'd0, pix_valid}, 32'd1);
    check(pix_out == exp, req, {8'd0, pix_out}, {8'd0, exp});
  endtask

  task automatic sync_to(input logic [2:0] code);
    @(negedge clk);
    fmt_sel = code; hsync = 1'b1;
    @(negedge clk);
    @(negedge clk);
    hsync = 1'b0;
  endtask

  function automatic logic [7:0] w5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, g, b;
    logic [4:0] r5, b5, g5;
    logic [5:0] g6;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(pix_valid == 1'b0, "R11 valid", {31'd0, pix_valid}, 32'd0);
    check(pix_out == 24'd0, "R11 pix_out", {8'd0, pix_out}, 32'd0);
    check(fmt_tag == 3'd0, "R11 fmt_tag", {29'd0, fmt_tag}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R5 code 0 sweep, R1 rising-edge capture
    sync_to(3'd0);
    @(negedge clk);
    check(fmt_tag == 3'd0, "R4 tag code 0", {29'd0, fmt_tag}, 32'd0);
    for (int i = 0; i < 64; i++) begin
      r = 8'(i * 37 + 5); g = 8'(i * 101 + 3); b = 8'(i * 59 + 11);
      pair_chk({g[3:0], b}, {r, g[7:4]}, 1'b1, {r, g, b}, "R5 code0 unpack");
    end

    // R4 fmt_sel change without sync has no effect
    fmt_sel = 3'd2;
    pair_chk(12'h3C5, 12'hA7B, 1'b1, 24'hA7B3C5, "R4 no change before sync");
    check(fmt_tag == 3'd0, "R4 tag held", {29'd0, fmt_tag}, 32'd0);

    // R10 RGB blanking
    pair_chk(12'hFFF, 12'hFFF, 1'b0, 24'd0, "R10 rgb blank");

    // R2 realign: a stray word then sync, next pair must be intact
    put_word(12'h555, 1'b1);
    sync_to(3'd0);
    pair_chk(12'h123, 12'h456, 1'b1, 24'h456123, "R2 realign after sync");

    // R6 code 1 sweep
    sync_to(3'd1);
    for (int i = 0; i < 64; i++) begin
      r = 8'(i * 29 + 7); g = 8'(i * 83 + 1); b = 8'(i * 13 + 200);
      pair_chk({g[2:0], b, g[4]}, {r, g[7:5], g[3]}, 1'b1, {r, g, b}, "R6 code1 unpack");
    end

    // R7 code 2 sweep, upper bits ignored
    sync_to(3'd2);
    @(negedge clk);
    check(fmt_tag == 3'd2, "R4 tag code 2", {29'd0, fmt_tag}, 32'd2);
    for (int i = 0; i < 64; i++) begin
      r5 = 5'(i * 7 + 3); g6 = 6'(i * 11 + 5); b5 = 5'(i * 3 + 1);
      pair_chk({4'hF, g6[2:0], b5}, {4'hA, r5, g6[5:3]}, 1'b1,
               {w5(r5), {g6, g6[5:4]}, w5(b5)}, "R7 code2 unpack");
    end

    // R8 code 3 sweep, word b bit 7 ignored
    sync_to(3'd3);
    for (int i = 0; i < 64; i++) begin
      r5 = 5'(i * 5 + 9); g5 = 5'(i * 13 + 2); b5 = 5'(i * 17 + 4);
      pair_chk({4'h5, g5[2:0], b5}, {4'h9, 1'b1, r5, g5[4:3]}, 1'b1,
               {w5(r5), w5(g5), w5(b5)}, "R8 code3 unpack");
    end

    // R9 / R10 chroma regrouping with lag and blanking
    sync_to(3'd4);
    @(negedge clk);
    check(fmt_tag == 3'd4, "R4 tag code 4", {29'd0, fmt_tag}, 32'd4);
    pair_chk(12'hA28, 12'hB64, 1'b1, 24'h108080, "R10 ycc first after sync blank");
    pair_chk(12'hCC8, 12'hD6E, 1'b1, {8'd100, 8'd200, 8'd40}, "R9 ycc Y0 Cr0 Cb0");
    pair_chk(12'h13C, 12'h278, 1'b0, {8'd110, 8'd200, 8'd40}, "R9 ycc Y1 shares chroma");
    pair_chk(12'h05A, 12'h082, 1'b1, 24'h108080, "R10 ycc blank luma");
    pair_chk(12'h046, 12'h08C, 1'b1, {8'd130, 8'd90, 8'd60}, "R9 ycc Y3 Cr1 Cb1");

    // R4 illegal code loads as 0
    sync_to(3'd6);
    @(negedge clk);
    check(fmt_tag == 3'd0, "R4 code 6 as 0", {29'd0, fmt_tag}, 32'd0);

    // R1 falling-edge capture; rising edge must capture nothing
    @(negedge clk);
    edge_sel = 1'b1; act_lvl = 1'b0; wclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(pix_valid == 1'b0, "R1 rising edge ignored", {31'd0, pix_valid}, 32'd0);
    sync_to(3'd0);
    pair_chk(12'h9AB, 12'hCDE, 1'b1, 24'hCDE9AB, "R1 falling edge capture");
    pair_chk(12'h001, 12'hFF0, 1'b1, 24'hFF0001, "R1 falling edge second pair");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule